// File: doc/BRIEF.md
# ATM Cell Header Error Checker

This block checks the five-byte header at the front of every ATM cell arriving on a byte-wide stream. A start-of-cell flag marks the first header byte. The block collects the header and recomputes the CRC-8 over the first four bytes, using the generator x^8+x^2+x+1. It XORs that value with the coset 0x55 and compares the result with the fifth byte. One cycle after the fifth byte it reports a verdict on the header and presents the header, repaired when repair is allowed.

A two-state mode machine controls repair. In correction mode, the block repairs a header whose syndrome matches exactly one flipped bit. In detection mode, every nonzero syndrome is treated as uncorrectable. The block enters detection mode after any header with a nonzero syndrome. It returns to correction mode only after a header with a zero syndrome.

Each uncorrectable header increments a saturating 32-bit counter and sets a sticky interrupt flag that drives an active-low interrupt pin. A processor reads the counter and the flag through a byte-wide read port with a same-cycle response. Reading an item clears it.

Top module: `atm_hec_checker`

## Requirements
- R1: `hdr_done` pulses for exactly one cycle, one clock after the fifth header byte is accepted. When the syndrome is zero, `hdr_status` is 2'b00 (clean) and `hdr_out` equals the received header, with byte 0 in bits 39:32 and the check byte in bits 7:0. The `hdr_status` value 2'b11 never appears.
- R2: In correction mode, a header whose syndrome matches a single flipped bit is reported as 2'b01 (corrected), and `hdr_out` carries that bit restored.
- R3: Any header with a nonzero syndrome puts the block in detection mode. In detection mode, every nonzero syndrome gives 2'b10 (uncorrectable) with `hdr_out` unrepaired. A zero-syndrome header returns the block to correction mode.
- R4: A nonzero syndrome that matches no single-bit pattern gives 2'b10 (uncorrectable) in either mode, with `hdr_out` unrepaired.
- R5: Every uncorrectable header increments a 32-bit counter. The counter is read at `rd_addr` 0 to 3, most significant byte first (0 = bits 31:24, 3 = bits 7:0), and it stops at all ones.
- R6: Reading address 0 captures all 32 counter bits for later reads of addresses 1 to 3 and clears the counter. An increment in the same cycle as that read leaves the counter at 1.
- R7: An uncorrectable header sets bit 2 of the status byte at address 4 and drives `irq_n` low. Reading address 4 returns the byte and clears it, and `irq_n` returns high. A flag set in the same cycle as that read survives.
- R8: While no header is being collected, bytes without `in_sof` are ignored. Cycles with `in_valid` low are ignored. `in_sof` in the middle of a header restarts collection with that byte as byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is valid |
| in_sof | input | 1 | Input byte is the first byte of a cell |
| in_byte | input | 8 | Input stream byte |
| hdr_done | output | 1 | Verdict strobe, one cycle |
| hdr_status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| hdr_out | output | 40 | Header, repaired when corrected |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | 0..3 counter bytes (MSB first), 4 status byte |
| rd_data | output | 8 | Read data, same cycle as `rd_en` |
| irq_n | output | 1 | Interrupt, active low |

## Verification
A wrong mode bit cannot be seen on the header that caused it. It shows up on the next header with a nonzero syndrome, as a 01 verdict where 10 was due, or the reverse. For that reason the stimulus places error-bearing headers back to back. Counter or flag faults show up in the cycle of the next read, or on `irq_n` one clock after the offending header. The checks therefore read the registers at the moments when an increment or a flag set meets a read.

// File: rtl/atm_hec_checker.sv
module atm_hec_checker #(
  parameter logic [7:0] COSET      = 8'h55,
  parameter logic [7:0] IRQ_ENABLE = 8'h04
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic [7:0]  in_byte,
  output logic        hdr_done,
  output logic [1:0]  hdr_status,
  output logic [39:0] hdr_out,
  input  logic        rd_en,
  input  logic [2:0]  rd_addr,
  output logic [7:0]  rd_data,
  output logic        irq_n
);

  localparam logic [1:0] ST_CLEAN = 2'b00;
  localparam logic [1:0] ST_FIXED = 2'b01;
  localparam logic [1:0] ST_BAD   = 2'b10;
  localparam logic [2:0] IDLE_POS = 3'd5;

  function automatic logic [7:0] crc8(input logic [31:0] d);
    logic [7:0] c;
    logic fb;
    c = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  function automatic logic [7:0] flip_syn(input int p);
    if (p < 8) return 8'(1 << p);
    return crc8(32'h1 << (p - 8));
  endfunction

  logic [31:0] hdr_q;
  logic [2:0]  pos;
  logic        det;
  logic [31:0] cnt, snap;
  logic [7:0]  stat;

  wire        last = in_valid && !in_sof && pos == 3'd4;
  wire        take = in_valid && (in_sof || pos < 3'd4);
  wire [39:0] full = {hdr_q, in_byte};
  wire [7:0]  syn  = crc8(hdr_q) ^ COSET ^ in_byte;
  logic [39:0] hit;

  for (genvar p = 0; p < 40; p++) begin : g_pat
    localparam logic [7:0] PAT = flip_syn(p);
    assign hit[p] = (syn == PAT);
  end

  logic [1:0] verdict;
  always_comb begin
    if (syn == 8'h00)       verdict = ST_CLEAN;
    else if (!det && |hit)  verdict = ST_FIXED;
    else                    verdict = ST_BAD;
  end

  wire bad     = last && verdict == ST_BAD;
  wire rd_cnt  = rd_en && rd_addr == 3'd0;
  wire rd_stat = rd_en && rd_addr == 3'd4;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_q <= '0;
      pos   <= IDLE_POS;
      det   <= 1'b0;
      hdr_done   <= 1'b0;
      hdr_status <= ST_CLEAN;
      hdr_out    <= '0;
    end else begin
      hdr_done <= last;
      if (take) begin
        hdr_q <= {hdr_q[23:0], in_byte};
        pos   <= in_sof ? 3'd1 : pos + 3'd1;
      end else if (last) begin
        pos        <= IDLE_POS;
        det        <= (syn != 8'h00);
        hdr_status <= verdict;
        hdr_out    <= (verdict == ST_FIXED) ? (full ^ hit) : full;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      snap <= '0;
      stat <= '0;
    end else begin
      if (rd_cnt) begin
        snap <= cnt;
        cnt  <= bad ? 32'd1 : 32'd0;
      end else if (bad && cnt != '1) begin
        cnt <= cnt + 32'd1;
      end
      if (bad)          stat[2] <= 1'b1;
      else if (rd_stat) stat    <= '0;
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = cnt[31:24];
      3'd1:    rd_data = snap[23:16];
      3'd2:    rd_data = snap[15:8];
      3'd3:    rd_data = snap[7:0];
      3'd4:    rd_data = stat;
      default: rd_data = 8'h00;
    endcase
  end

  assign irq_n = ~|(stat & IRQ_ENABLE);

  AST_NO_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_done |-> hdr_status != 2'b11); // R1
  AST_ERR_ENTERS_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && hdr_status != ST_CLEAN) |-> det); // R3
  AST_FIX_ONLY_IN_CORRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && hdr_status == ST_FIXED) |-> !$past(det)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 32'd1 || cnt <= 32'd1)); // R5
  AST_IRQ_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && hdr_status == ST_BAD) |-> !irq_n); // R7

endmodule

// File: tb/atm_hec_checker_bench.sv
`timescale 1ns/1ps
module atm_hec_checker_bench;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sof = 0;
  logic [7:0] in_byte = 0;
  logic hdr_done, irq_n;
  logic [1:0] hdr_status;
  logic [39:0] hdr_out;
  logic rd_en = 0;
  logic [2:0] rd_addr = 0;
  logic [7:0] rd_data;

  atm_hec_checker u_atm_hec_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_byte(in_byte),
    .hdr_done(hdr_done), .hdr_status(hdr_status), .hdr_out(hdr_out),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit m_det = 0;
  logic [31:0] m_cnt = 0, m_snap = 0;
  logic [7:0] m_stat = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bcrc(input logic [31:0] d);
    logic [7:0] c = 0;
    for (int b = 3; b >= 0; b--) begin
      c ^= d[b*8 +: 8];
      for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  function automatic bit good(input logic [39:0] h);
    return (bcrc(h[39:8]) ^ 8'h55) == h[7:0];
  endfunction

  function automatic logic [39:0] mk(input logic [31:0] d);
    return {d, bcrc(d) ^ 8'h55};
  endfunction

  task automatic expect_of(input logic [39:0] h, output logic [1:0] st, output logic [39:0] o);
    st = 2'b10; o = h;
    if (good(h)) st = 2'b00;
    else if (!m_det)
      for (int p = 0; p < 40; p++)
        if (good(h ^ (40'd1 << p))) begin st = 2'b01; o = h ^ (40'd1 << p); end
    m_det = !good(h);
  endtask

  task automatic drv(input bit v, input bit s, input logic [7:0] b);
    @(negedge clk); in_valid = v; in_sof = s; in_byte = b;
  endtask

  task automatic send_hdr(input logic [39:0] h, input bit gaps, input bit rd0, input bit rd4,
                          input string req);
    logic [1:0] est; logic [39:0] eo; logic [7:0] rv;
    for (int i = 0; i < 5; i++) begin
      if (gaps && $urandom_range(0, 2) == 0) drv(0, 0, 8'hA5);
      drv(1, i == 0, h[39 - 8*i -: 8]);
      if (i == 4 && (rd0 || rd4)) begin
        rd_en = 1; rd_addr = rd0 ? 3'd0 : 3'd4;
        #1 rv = rd_data;
        if (rd4) check("R7 status read on set", rv, m_stat);
      end
    end
    expect_of(h, est, eo);
    if (rd0) begin m_snap = m_cnt; m_cnt = 0; end
    if (rd4) m_stat = 0;
    if (est == 2'b10) begin
      if (m_cnt != 32'hFFFF_FFFF) m_cnt++;
      m_stat[2] = 1;
    end
    drv(0, 0, 0); rd_en = 0;
    check({req, " done"}, hdr_done, 1);
    check({req, " status"}, hdr_status, est);
    check({req, " header"}, hdr_out, eo);
    check("R7 irq_n", irq_n, !m_stat[2]);
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); rd_en = 1; rd_addr = a;
    #1 check(req, rd_data, exp);
    if (a == 0) begin m_snap = m_cnt; m_cnt = 0; end
    if (a == 4) m_stat = 0;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic read_cnt(input string req);
    logic [31:0] v = m_cnt;
    rd(0, v[31:24], req); rd(1, v[23:16], req); rd(2, v[15:8], req); rd(3, v[7:0], req);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [39:0] h;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset done", hdr_done, 0);
    check("R7 reset irq_n", irq_n, 1);
    rd(4, 8'h00, "R7 reset status");
    read_cnt("R5 reset count");

    h = mk(32'h0000_0000); send_hdr(h, 0, 0, 0, "R1 clean zero");
    h = mk(32'h1234_5678); send_hdr(h, 1, 0, 0, "R1 clean gaps");
    h = mk(32'hDEAD_BEEF) ^ (40'd1 << 30); send_hdr(h, 0, 0, 0, "R2 data bit fix");
    h = mk(32'h0102_0304) ^ (40'd1 << 3); send_hdr(h, 0, 0, 0, "R3 detect no fix");
    rd(4, 8'h04, "R7 status set");
    check("R7 irq_n after clear", irq_n, 1);
    rd(4, 8'h00, "R7 status cleared");
    h = mk(32'hCAFE_0001); send_hdr(h, 0, 0, 0, "R3 back to correct");
    h = mk(32'hCAFE_0002) ^ (40'd1 << 2); send_hdr(h, 0, 0, 0, "R2 hec bit fix");
    h = mk(32'hCAFE_0003); send_hdr(h, 0, 0, 0, "R3 clean returns");
    h = mk(32'h5555_AAAA) ^ 40'h00_0000_0003; send_hdr(h, 0, 0, 0, "R4 double bit");
    h = mk(32'h7777_7777); send_hdr(h, 0, 0, 0, "R3 clean");
    h = mk(32'h0F0F_0F0F) ^ (40'h7 << 20); send_hdr(h, 0, 0, 0, "R4 triple bit");
    read_cnt("R5 count bytes");
    read_cnt("R6 cleared after read");

    drv(1, 1, 8'h11); drv(1, 0, 8'h22);
    h = mk(32'hABCD_EF01); send_hdr(h, 0, 0, 0, "R8 sof restart");
    for (int i = 0; i < 6; i++) drv(1, 0, 8'hFF);
    drv(0, 0, 0);
    check("R8 payload ignored done", hdr_done, 0);
    check("R8 payload ignored header", hdr_out, h);

    h = mk(32'h1111_2222) ^ 40'h0300; send_hdr(h, 0, 0, 0, "R4 setup");
    h = mk(32'h3333_4444) ^ 40'h0300; send_hdr(h, 0, 1, 0, "R6 read collide");
    check("R6 snapshot source", m_snap, 32'd1);
    rd(3, m_snap[7:0], "R6 snapshot low byte");
    rd(1, m_snap[23:16], "R6 snapshot byte1");
    read_cnt("R6 kept increment");
    rd(4, 8'h04, "R7 pending flag");
    h = mk(32'h9999_0000) ^ 40'h0500; send_hdr(h, 0, 0, 1, "R7 read collide");
    check("R7 flag survives irq", irq_n, 0);
    rd(4, 8'h04, "R7 flag survives");
    check("R7 irq released", irq_n, 1);

    for (int n = 0; n < 300; n++) begin
      logic [39:0] e = 0;
      int kind = $urandom_range(0, 3);
      for (int k = 0; k < kind; k++) e[$urandom_range(0, 39)] = 1'b1;
      h = mk($urandom()) ^ e;
      send_hdr(h, 1, 0, 0, kind <= 1 ? "R2 random" : "R4 random");
      repeat ($urandom_range(0, 3)) drv($urandom_range(0, 1), 0, 8'($urandom()));
      if (n % 25 == 24) begin read_cnt("R5 random count"); rd(4, m_stat, "R7 random status"); end
    end
    read_cnt("R5 final count");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule